// File: doc/BRIEF.md
# Page Address Translator with Associative Cache

This block turns logical addresses coming from a processor into physical addresses. The logical address splits into a page number (upper bits) and a byte offset within the page (lower bits). The offset is carried across unchanged. The page number is replaced by a frame number.

The frame number comes first from a small, fully associative translation cache that compares every stored page number at once. When the page is not cached, the block reads one entry of a single-level page table held in memory. The entry sits at the table base register plus the page number. If that entry is marked valid, the block installs it in the cache and answers. If it is marked invalid, the block returns a fault and no address.

A flush input empties the cache in one cycle. Loading a new table base also empties it, because the old translations no longer apply. Two free-running counters report lookups that hit and lookups that missed, so the hit ratio can be measured.

Top module: `page_xlate_top`

## Requirements
- R1: The low OFF_W bits of `req_vaddr` appear unchanged as the low OFF_W bits of `resp_paddr`; the upper bits of `resp_paddr` are the frame number.
- R2: When a request is accepted and its page number is in the cache, `resp_valid` is high on the next cycle with the cached translation, and no memory read is issued.
- R3: When a request is accepted and its page number is not cached, exactly one single-cycle `mem_rd_en` pulse follows on the next cycle, with `mem_rd_addr` = table base + page number. The response follows on the cycle after `mem_rd_valid`.
- R4: A table entry is FRAME_W+1 bits wide. Bit 0 is the valid flag and bits [FRAME_W:1] are the frame number. A valid entry is installed in the cache, so the next access to that page hits.
- R5: An entry with bit 0 clear makes `resp_fault` high together with `resp_valid`, with `resp_paddr` zero. The entry is not cached, so a repeat access misses again.
- R6: A fill goes to the lowest-numbered empty cache slot if one exists. Otherwise it goes to the slot named by a round-robin pointer. The pointer starts at 0 after reset, advances by one (wrapping) on every fill, and is not moved by a flush. No page number is held in two slots.
- R7: Asserting `flush` for one cycle empties every cache slot, so the next access to any page misses.
- R8: Asserting `ptbr_we` loads `ptbr_wdata` as the table base for later misses and empties the cache as `flush` does.
- R9: `hit_count` rises by one for each accepted request that hits. `miss_count` rises by one for each accepted request that misses, faulting ones included.
- R10: After reset the counters are zero, `resp_valid` and `mem_rd_en` are low, `req_ready` is high and the cache is empty. `req_ready` is low from the miss until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Logical address |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | PA_W | Physical address (zero on fault) |
| resp_fault | output | 1 | Page marked invalid |
| mem_rd_en | output | 1 | Table-entry read strobe |
| mem_rd_addr | output | PA_W | Table-entry address |
| mem_rd_valid | input | 1 | Table-entry data returned |
| mem_rd_data | input | FRAME_W+1 | Table entry: frame, valid bit 0 |
| ptbr_we | input | 1 | Load table base and flush |
| ptbr_wdata | input | PA_W | New table base |
| flush | input | 1 | Empty the cache |
| hit_count | output | CNT_W | Accepted requests that hit |
| miss_count | output | CNT_W | Accepted requests that missed |

## Verification
The hardest case to reach from the ports is replacement with a full cache. There the round-robin pointer, not the empty-slot search, picks the victim, and the pointer's position depends on every fill since reset, including fills made into empty slots after flushes. The bench fills all slots with distinct valid pages and then touches a new page, which forces an eviction. It then runs thousands of random requests over a page range larger than the cache, with occasional flushes and base changes. A bench model of the slots and pointer predicts every hit, miss and table address.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_ISSUE = 2'd1,
    WALK_WAIT  = 2'd2
  } walk_state_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               hit,
  output logic [FRAME_W-1:0] hit_frame,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame
);
  logic [FRAME_W-1:0] frame_arr [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic               v_q;
    logic [VPN_W-1:0]   tag_q;
    logic [FRAME_W-1:0] frm_q;
    logic               sel;

    assign sel = fill_en && (fill_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      v_q <= 1'b0;
      else if (clear)  v_q <= 1'b0;
      else if (sel)    v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q <= fill_vpn;
        frm_q <= fill_frame;
      end
    end

    assign valid_vec[e] = v_q;
    assign match_vec[e] = v_q && (tag_q == lk_vpn);
    assign frame_arr[e] = frm_q;
  end

  assign hit = |match_vec;

  always_comb begin
    hit_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_frame = hit_frame | frame_arr[i];
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign victim_idx = free_found ? free_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else if (fill_en)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/xlate_counters.sv
module xlate_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_evt,
  input  logic             miss_evt,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (hit_evt)  hit_count  <= hit_count + 1'b1;
      if (miss_evt) miss_count <= miss_count + 1'b1;
    end
  end
endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top
  import xlate_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 32,
  parameter int CNT_W   = 32,
  localparam int VPN_W   = VA_W - OFF_W,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int PTE_W   = FRAME_W + 1,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_fault,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data,
  input  logic             ptbr_we,
  input  logic [PA_W-1:0]  ptbr_wdata,
  input  logic             flush,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] pte_addr(input logic [PA_W-1:0] base,
                                               input logic [VPN_W-1:0] vpn);
    return base + PA_W'(vpn);
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [FRAME_W-1:0] frm,
                                              input logic [OFF_W-1:0] off);
    return {frm, off};
  endfunction

  function automatic logic pte_ok(input logic [PTE_W-1:0] pte);
    return pte[0];
  endfunction

  function automatic logic [FRAME_W-1:0] pte_frame(input logic [PTE_W-1:0] pte);
    return pte[FRAME_W:1];
  endfunction

  walk_state_t        state_q;
  logic [VPN_W-1:0]   sv_vpn_q;
  logic [OFF_W-1:0]   sv_off_q;
  logic [PA_W-1:0]    ptbr_q;
  logic               resp_valid_q;
  logic               resp_fault_q;
  logic [PA_W-1:0]    resp_paddr_q;

  logic               cam_hit;
  logic [FRAME_W-1:0] cam_frame;
  logic [ENTRIES-1:0] cam_match;
  logic [ENTRIES-1:0] cam_valid;
  logic               cam_clear;
  logic               fill_en;
  logic [IDX_W-1:0]   fill_idx;
  logic               accept;
  logic               lookup_hit;
  logic               lookup_miss;
  logic               walk_done;

  assign req_ready   = (state_q == WALK_IDLE);
  assign accept      = req_valid && req_ready;
  assign lookup_hit  = accept && cam_hit;
  assign lookup_miss = accept && !cam_hit;
  assign walk_done   = (state_q == WALK_WAIT) && mem_rd_valid;
  assign fill_en     = walk_done && pte_ok(mem_rd_data);
  assign cam_clear   = flush || ptbr_we;

  assign mem_rd_en   = (state_q == WALK_ISSUE);
  assign mem_rd_addr = pte_addr(ptbr_q, sv_vpn_q);

  assign resp_valid  = resp_valid_q;
  assign resp_fault  = resp_fault_q;
  assign resp_paddr  = resp_paddr_q;

  tlb_cam #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .FRAME_W (FRAME_W)
  ) u_cam (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cam_clear),
    .lk_vpn     (vpn_of(req_vaddr)),
    .hit        (cam_hit),
    .hit_frame  (cam_frame),
    .match_vec  (cam_match),
    .valid_vec  (cam_valid),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .fill_vpn   (sv_vpn_q),
    .fill_frame (pte_frame(mem_rd_data))
  );

  tlb_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (cam_valid),
    .fill_en    (fill_en),
    .victim_idx (fill_idx)
  );

  xlate_counters #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_evt    (lookup_hit),
    .miss_evt   (lookup_miss),
    .hit_count  (hit_count),
    .miss_count (miss_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= WALK_IDLE;
      sv_vpn_q     <= '0;
      sv_off_q     <= '0;
      ptbr_q       <= '0;
      resp_valid_q <= 1'b0;
      resp_fault_q <= 1'b0;
      resp_paddr_q <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      resp_fault_q <= 1'b0;
      if (ptbr_we) ptbr_q <= ptbr_wdata;
      case (state_q)
        WALK_IDLE: begin
          if (lookup_hit) begin
            resp_valid_q <= 1'b1;
            resp_paddr_q <= join_pa(cam_frame, off_of(req_vaddr));
          end else if (lookup_miss) begin
            sv_vpn_q <= vpn_of(req_vaddr);
            sv_off_q <= off_of(req_vaddr);
            state_q  <= WALK_ISSUE;
          end
        end
        WALK_ISSUE: state_q <= WALK_WAIT;
        WALK_WAIT: begin
          if (walk_done) begin
            resp_valid_q <= 1'b1;
            state_q      <= WALK_IDLE;
            if (pte_ok(mem_rd_data)) begin
              resp_paddr_q <= join_pa(pte_frame(mem_rd_data), sv_off_q);
            end else begin
              resp_fault_q <= 1'b1;
              resp_paddr_q <= '0;
            end
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int ENTRIES = 32,
  parameter int PA_W    = 32,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               resp_valid,
  input logic               resp_fault,
  input logic [PA_W-1:0]    resp_paddr,
  input logic               mem_rd_en,
  input logic               flush,
  input logic               ptbr_we,
  input logic               lookup_hit,
  input logic               lookup_miss,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   miss_count
);
  assert_hit_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> (resp_valid && !resp_fault));

  assert_hit_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> !mem_rd_en);

  assert_miss_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_miss |=> mem_rd_en);

  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  assert_fault_no_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> (resp_valid && (resp_paddr == '0)));

  assert_unique_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  assert_base_flushes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptbr_we |=> (valid_vec == '0));

  assert_hit_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> $past(lookup_hit));

  assert_miss_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != $past(miss_count)) |-> $past(lookup_miss));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);
endmodule

bind page_xlate_top xlate_checker #(
  .ENTRIES (ENTRIES),
  .PA_W    (PA_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .resp_fault  (resp_fault),
  .resp_paddr  (resp_paddr),
  .mem_rd_en   (mem_rd_en),
  .flush       (flush),
  .ptbr_we     (ptbr_we),
  .lookup_hit  (lookup_hit),
  .lookup_miss (lookup_miss),
  .match_vec   (cam_match),
  .valid_vec   (cam_valid),
  .hit_count   (hit_count),
  .miss_count  (miss_count)
);

// File: tb/sim_page_xlate_top.sv
`timescale 1ns/1ps
module sim_page_xlate_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic        resp_fault;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [20:0] mem_rd_data = '0;
  logic        ptbr_we = 1'b0;
  logic [31:0] ptbr_wdata = '0;
  logic        flush = 1'b0;
  logic [31:0] hit_count;
  logic [31:0] miss_count;

  always #4 clk = ~clk;

  page_xlate_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_fault(resp_fault), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .ptbr_we(ptbr_we),
    .ptbr_wdata(ptbr_wdata), .flush(flush), .hit_count(hit_count),
    .miss_count(miss_count)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // table content: entry invalid when (address & 7) == 3
  function automatic logic [20:0] table_entry(input logic [31:0] a);
    logic [31:0] h;
    h = (a * 32'h9E3779B1) ^ (a >> 5);
    return {h[19:0], ((a & 32'd7) != 32'd3)};
  endfunction

  // memory model with random latency
  int          rd_cnt = 0;
  logic [31:0] cap_addr = '0;
  bit          pend = 0;
  int          wait_c = 0;
  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_en) begin
      pend     <= 1;
      wait_c   <= $urandom_range(0, 3);
      cap_addr <= mem_rd_addr;
      rd_cnt   <= rd_cnt + 1;
    end else if (pend) begin
      if (wait_c == 0) begin
        pend         <= 0;
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= table_entry(cap_addr);
      end else begin
        wait_c <= wait_c - 1;
      end
    end
  end

  // reference model of the cache
  bit          m_v [N];
  logic [19:0] m_vpn [N];
  int          m_rr = 0;
  logic [31:0] m_base = '0;
  int          e_hits = 0;
  int          e_miss = 0;

  function automatic bit m_has(input logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return 1;
    return 0;
  endfunction

  function automatic void m_fill(input logic [19:0] vpn);
    int idx = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
    if (idx < 0) idx = m_rr;
    m_v[idx] = 1;
    m_vpn[idx] = vpn;
    m_rr = (m_rr + 1) % N;
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endfunction

  task automatic do_req(input logic [19:0] vpn, input logic [11:0] off, input string tag);
    bit          exp_hit;
    int          rd0;
    int          cyc;
    logic [20:0] pte;
    logic [31:0] exp_addr;
    exp_hit  = m_has(vpn);
    exp_addr = m_base + {12'd0, vpn};
    pte      = table_entry(exp_addr);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", {tag, " ready when idle"}, req_ready, 1);
    rd0 = rd_cnt;
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    if (exp_hit) begin
      e_hits++;
      chk(resp_valid == 1'b1, "R2", {tag, " hit latency"}, resp_valid, 1);
    end else begin
      e_miss++;
      chk(req_ready == 1'b0, "R10", {tag, " busy during miss"}, req_ready, 0);
      while (!resp_valid && cyc < 100) begin
        @(negedge clk);
        cyc++;
      end
      chk(cap_addr == exp_addr, "R3", {tag, " entry address"}, cap_addr, exp_addr);
    end
    chk(resp_valid == 1'b1, exp_hit ? "R2" : "R3", {tag, " response"}, resp_valid, 1);
    chk(rd_cnt - rd0 == (exp_hit ? 0 : 1), exp_hit ? "R2" : "R3",
        {tag, " memory reads"}, rd_cnt - rd0, exp_hit ? 0 : 1);
    if (exp_hit || pte[0]) begin
      chk(resp_fault == 1'b0, "R4", {tag, " no fault"}, resp_fault, 0);
      chk(resp_paddr == {pte[20:1], off}, "R1", {tag, " physical address"},
          resp_paddr, {pte[20:1], off});
      if (!exp_hit) m_fill(vpn);
    end else begin
      chk(resp_fault == 1'b1, "R5", {tag, " fault"}, resp_fault, 1);
      chk(resp_paddr == 32'd0, "R5", {tag, " zero on fault"}, resp_paddr, 0);
    end
    chk(hit_count == 32'(e_hits), "R9", {tag, " hit count"}, hit_count, e_hits);
    chk(miss_count == 32'(e_miss), "R9", {tag, " miss count"}, miss_count, e_miss);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    m_clear();
  endtask

  task automatic do_base(input logic [31:0] b);
    @(negedge clk);
    ptbr_we = 1'b1;
    ptbr_wdata = b;
    @(negedge clk);
    ptbr_we = 1'b0;
    m_base = b;
    m_clear();
  endtask

  initial begin
    void'($urandom(32'd2024));
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hit_count == 0 && miss_count == 0, "R10", "reset counters", {hit_count, miss_count}, 0);
    chk(resp_valid == 0 && mem_rd_en == 0, "R10", "reset strobes", {resp_valid, mem_rd_en}, 0);
    chk(req_ready == 1, "R10", "reset ready", req_ready, 1);

    do_base(32'h0000_1000);
    do_req(20'd5, 12'h123, "R4 first touch");
    do_req(20'd5, 12'hFED, "R2 R1 second touch");
    do_req(20'd3, 12'h010, "R5 invalid");
    do_req(20'd3, 12'h010, "R5 invalid repeat");
    do_flush();
    do_req(20'd5, 12'h001, "R7 after flush");
    do_base(32'h0002_0000);
    do_req(20'd5, 12'h002, "R8 new base");
    do_req(20'd5, 12'h003, "R8 new base hit");

    // R6: fill every slot with distinct valid pages, then evict
    do_flush();
    for (int i = 0; i < N; i++) do_req(20'(i * 8), 12'(i), "R6 fill");
    do_req(20'd1000, 12'h0AA, "R6 evict");
    for (int i = 0; i < 4; i++) do_req(20'(i * 8), 12'h055, "R6 after evict");

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) do_flush();
      else if (r < 3) do_base({$urandom_range(0, 15), 12'h000});
      else do_req(20'($urandom_range(0, 47)), 12'($urandom), "R6 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule